// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects the event flags of a seven-channel display DMA engine and turns them into one level interrupt. Each channel reports start of frame, end of frame, branch taken, bus error and input underrun as single-cycle pulses. The controller itself reports last frame done, AC-bias count, output underrun, read status and command done. The flags are held in two sticky status words. Channel 0 and the controller events go to the primary word. Channels 1 to 6 go to a secondary word, where each event kind occupies one byte lane indexed by channel number.

Each flag has a mask bit at the same position. When a recorded channel event is unmasked, or when a bus error occurs, the block sets a summary flag and latches that channel's frame ID into a last-interrupt-ID register. Software clears flags by writing ones. A small write/read port reaches six registers: 0 enable control (bit 0), 1 primary mask (bits 12:0), 2 secondary mask (bits 29:0), 3 primary status, 4 secondary status and 5 last interrupt ID (read only). Any other address reads as zero.

Top module: `dc_irq_status`

## Requirements
- R1: After reset, both status words, both masks, the enable bit and the interrupt ID read 0, and irq_o is low.
- R2: Channel 0 events set these primary bits: start of frame at bit 1 (recorded only if sof_req_i[0] is 1), end of frame at bit 8 (recorded only if eof_req_i[0] is 1), branch at bit 9 and input underrun at bit 4.
- R3: For channel c in 1..6, the secondary word takes start of frame at bit c-1, end of frame at bit c+7, branch at bit c+15 and underrun at bit c+23. Start and end of frame are gated by that channel's request bits. A channel-1 underrun also sets primary bit 5.
- R4: A bus error on any channel sets primary bit 2 and writes the channel number into primary bits 30:28. When several channels fail in the same cycle, the lowest channel number is recorded.
- R5: A recorded start-of-frame, end-of-frame or branch event whose mask bit is 0, or any bus error, sets primary bit 10 and loads the interrupt ID with that channel's frame ID (lowest channel first). A masked event changes neither bit 10 nor the ID.
- R6: A write to the primary status word clears each of bits 11:0 that is written as 1. Bit 12 is not cleared this way. Writing 1 to bit 2 also zeroes bits 30:28.
- R7: A write to the secondary status word clears only those written-1 bits that fall within 0x3e3f3f. Every other secondary bit keeps its value.
- R8: A write of 0 to the enable bit while it is 1 sets primary bit 7 (quick disable done). Writes that leave the bit at 0, or that set it, do not set bit 7.
- R9: The controller events set these primary bits: last frame done at bit 0, AC-bias count at bit 3, output underrun at bit 6, read status at bit 11 and command done at bit 12.
- R10: irq_o is a register. It equals the OR of (primary bits 12:0 AND NOT primary mask) with (secondary bits AND NOT secondary mask), as those values stood one clock earlier.
- R11: When a new event and a clearing write hit the same flag or channel field in one cycle, the event's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | N_CH | Start-of-frame pulses, one per channel |
| eof_i | input | N_CH | End-of-frame pulses |
| brs_i | input | N_CH | Branch-taken pulses |
| berr_i | input | N_CH | Bus-error pulses |
| undr_i | input | N_CH | Input-underrun pulses |
| sof_req_i | input | N_CH | Per-channel start-of-frame request bit from the command word |
| eof_req_i | input | N_CH | Per-channel end-of-frame request bit from the command word |
| frame_id_i | input | N_CH*IDW | Current frame ID of each channel, channel c at [c*IDW +: IDW] |
| ldd_i | input | 1 | Last frame done pulse |
| acb_i | input | 1 | AC-bias count pulse |
| oundr_i | input | 1 | Output underrun pulse |
| rdst_i | input | 1 | Read status pulse |
| cmdd_i | input | 1 | Command done pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Registered interrupt level |

## Verification
A flag that is missed, or that lands in the wrong position, shows on the read port at the first negative edge after the pulse. It also shows on irq_o one cycle later, because the interrupt is computed from the stored flags. A wrong priority choice shows up as the wrong channel field or the wrong interrupt ID on the cycle after the event. A clear mask that is too wide or too narrow leaves visible leftovers after a single write of all ones. Stale mask state shows as irq_o failing to follow a mask write within two edges.

// File: rtl/dc_irq_pkg.sv
package dc_irq_pkg;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int PW     = 13;
  localparam int SW     = 30;
  localparam int BCH_W  = 3;
  localparam int BCH_LO = 28;
  localparam int PCLR_W = 12;
  localparam logic [SW-1:0] SCLR_MASK = 30'h003e_3f3f;

  localparam int P_LDD  = 0;
  localparam int P_SOF0 = 1;
  localparam int P_BER  = 2;
  localparam int P_ACB  = 3;
  localparam int P_UR0  = 4;
  localparam int P_UR1  = 5;
  localparam int P_OUR  = 6;
  localparam int P_QD   = 7;
  localparam int P_EOF0 = 8;
  localparam int P_BS0  = 9;
  localparam int P_SUM  = 10;
  localparam int P_RDST = 11;
  localparam int P_CMD  = 12;

  localparam int S_SOF_OFS = -1;
  localparam int S_EOF_OFS = 7;
  localparam int S_BS_OFS  = 15;
  localparam int S_UR_OFS  = 23;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_PMASK = 3'd1,
    A_SMASK = 3'd2,
    A_PSTAT = 3'd3,
    A_SSTAT = 3'd4,
    A_LIID  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/dc_irq_capture.sv
module dc_irq_capture
  import dc_irq_pkg::*;
#(
  parameter int N_CH = 7,
  parameter int IDW  = 32
) (
  input  logic [N_CH-1:0]     sof_i,
  input  logic [N_CH-1:0]     eof_i,
  input  logic [N_CH-1:0]     brs_i,
  input  logic [N_CH-1:0]     berr_i,
  input  logic [N_CH-1:0]     undr_i,
  input  logic [N_CH-1:0]     sof_req_i,
  input  logic [N_CH-1:0]     eof_req_i,
  input  logic [N_CH*IDW-1:0] frame_id_i,
  input  logic                ldd_i,
  input  logic                acb_i,
  input  logic                oundr_i,
  input  logic                rdst_i,
  input  logic                cmdd_i,
  input  logic [PW-1:0]       pmask_i,
  input  logic [SW-1:0]       smask_i,
  output logic [PW-1:0]       pset_o,
  output logic [SW-1:0]       sset_o,
  output logic                ber_hit_o,
  output logic [BCH_W-1:0]    ber_ch_o,
  output logic                sum_hit_o,
  output logic [IDW-1:0]      sum_id_o
);
  logic [N_CH-1:0] q_sof, q_eof, unm, hit;
  logic [SW-1:0]   sset_ch [N_CH];

  assign q_sof = sof_i & sof_req_i;
  assign q_eof = eof_i & eof_req_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c == 0) begin : g_pri
      assign sset_ch[c] = '0;
      assign unm[c] = (q_sof[c] & ~pmask_i[P_SOF0]) |
                      (q_eof[c] & ~pmask_i[P_EOF0]) |
                      (brs_i[c] & ~pmask_i[P_BS0]);
    end else begin : g_sec
      logic [SW-1:0] v;
      always_comb begin
        v = '0;
        v[c+S_SOF_OFS] = q_sof[c];
        v[c+S_EOF_OFS] = q_eof[c];
        v[c+S_BS_OFS]  = brs_i[c];
        v[c+S_UR_OFS]  = undr_i[c];
      end
      assign sset_ch[c] = v;
      assign unm[c] = (q_sof[c] & ~smask_i[c+S_SOF_OFS]) |
                      (q_eof[c] & ~smask_i[c+S_EOF_OFS]) |
                      (brs_i[c] & ~smask_i[c+S_BS_OFS]);
    end
  end

  assign hit = unm | berr_i;

  always_comb begin
    sset_o = '0;
    for (int c = 0; c < N_CH; c++) sset_o = sset_o | sset_ch[c];
  end

  always_comb begin
    pset_o         = '0;
    pset_o[P_LDD]  = ldd_i;
    pset_o[P_SOF0] = q_sof[0];
    pset_o[P_BER]  = |berr_i;
    pset_o[P_ACB]  = acb_i;
    pset_o[P_UR0]  = undr_i[0];
    pset_o[P_UR1]  = undr_i[1];
    pset_o[P_OUR]  = oundr_i;
    pset_o[P_EOF0] = q_eof[0];
    pset_o[P_BS0]  = brs_i[0];
    pset_o[P_RDST] = rdst_i;
    pset_o[P_CMD]  = cmdd_i;
  end

  // scan downward so the lowest channel is applied last and wins
  always_comb begin
    sum_id_o = '0;
    ber_ch_o = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (hit[c])    sum_id_o = frame_id_i[c*IDW +: IDW];
      if (berr_i[c]) ber_ch_o = BCH_W'(c);
    end
  end

  assign sum_hit_o = |hit;
  assign ber_hit_o = |berr_i;
endmodule

// File: rtl/dc_irq_regs.sv
module dc_irq_regs
  import dc_irq_pkg::*;
#(
  parameter int IDW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [PW-1:0]    pset_i,
  input  logic [SW-1:0]    sset_i,
  input  logic             ber_hit_i,
  input  logic [BCH_W-1:0] ber_ch_i,
  input  logic             sum_hit_i,
  input  logic [IDW-1:0]   sum_id_i,
  output logic             ctrl_en_o,
  output logic [PW-1:0]    pmask_o,
  output logic [SW-1:0]    smask_o,
  output logic [DW-1:0]    pstat_o,
  output logic [SW-1:0]    sstat_o,
  output logic [DW-1:0]    rd_data_o
);
  logic             ctrl_en_q;
  logic [PW-1:0]    pmask_q, pflag_q, pflag_d, pset_x, pclr;
  logic [SW-1:0]    smask_q, sstat_q, sclr;
  logic [BCH_W-1:0] bch_q, bch_d;
  logic [IDW-1:0]   liid_q;
  logic             wr_ctrl, wr_pm, wr_sm, wr_ps, wr_ss, qd_set;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_pm   = wr_en_i && (wr_addr_i == A_PMASK);
  assign wr_sm   = wr_en_i && (wr_addr_i == A_SMASK);
  assign wr_ps   = wr_en_i && (wr_addr_i == A_PSTAT);
  assign wr_ss   = wr_en_i && (wr_addr_i == A_SSTAT);

  assign qd_set = wr_ctrl && ctrl_en_q && !wr_data_i[0];
  assign pclr   = wr_ps ? PW'(wr_data_i[PCLR_W-1:0]) : '0;
  assign sclr   = wr_ss ? (wr_data_i[SW-1:0] & SCLR_MASK) : '0;

  always_comb begin
    pset_x        = pset_i;
    pset_x[P_QD]  = pset_i[P_QD] | qd_set;
    pset_x[P_SUM] = pset_i[P_SUM] | sum_hit_i;
    pflag_d       = (pflag_q & ~pclr) | pset_x;
    if (ber_hit_i)                   bch_d = ber_ch_i;
    else if (wr_ps && wr_data_i[P_BER]) bch_d = '0;
    else                             bch_d = bch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      pmask_q   <= '0;
      smask_q   <= '0;
      pflag_q   <= '0;
      sstat_q   <= '0;
      bch_q     <= '0;
      liid_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_en_q <= wr_data_i[0];
      if (wr_pm)   pmask_q   <= wr_data_i[PW-1:0];
      if (wr_sm)   smask_q   <= wr_data_i[SW-1:0];
      pflag_q <= pflag_d;
      sstat_q <= (sstat_q & ~sclr) | sset_i;
      bch_q   <= bch_d;
      if (sum_hit_i) liid_q <= sum_id_i;
    end
  end

  always_comb begin
    pstat_o = '0;
    pstat_o[PW-1:0] = pflag_q;
    pstat_o[BCH_LO +: BCH_W] = bch_q;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:  rd_data_o[0] = ctrl_en_q;
      A_PMASK: rd_data_o[PW-1:0] = pmask_q;
      A_SMASK: rd_data_o[SW-1:0] = smask_q;
      A_PSTAT: rd_data_o = pstat_o;
      A_SSTAT: rd_data_o[SW-1:0] = sstat_q;
      A_LIID:  rd_data_o[IDW-1:0] = liid_q;
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_en_o = ctrl_en_q;
  assign pmask_o   = pmask_q;
  assign smask_o   = smask_q;
  assign sstat_o   = sstat_q;
endmodule

// File: rtl/dc_irq_out.sv
module dc_irq_out
  import dc_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pflag_i,
  input  logic [PW-1:0] pmask_i,
  input  logic [SW-1:0] sstat_i,
  input  logic [SW-1:0] smask_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(pflag_i & ~pmask_i)) | (|(sstat_i & ~smask_i));
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dc_irq_status.sv
module dc_irq_status
  import dc_irq_pkg::*;
#(
  parameter int N_CH = 7,
  parameter int IDW  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CH-1:0]     sof_i,
  input  logic [N_CH-1:0]     eof_i,
  input  logic [N_CH-1:0]     brs_i,
  input  logic [N_CH-1:0]     berr_i,
  input  logic [N_CH-1:0]     undr_i,
  input  logic [N_CH-1:0]     sof_req_i,
  input  logic [N_CH-1:0]     eof_req_i,
  input  logic [N_CH*IDW-1:0] frame_id_i,
  input  logic                ldd_i,
  input  logic                acb_i,
  input  logic                oundr_i,
  input  logic                rdst_i,
  input  logic                cmdd_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic                irq_o
);
  logic [PW-1:0]    pset_w, pmask_w;
  logic [SW-1:0]    sset_w, smask_w, sstat_w;
  logic [DW-1:0]    pstat_w;
  logic             ber_hit_w, sum_hit_w, ctrl_w;
  logic [BCH_W-1:0] ber_ch_w;
  logic [IDW-1:0]   sum_id_w;

  dc_irq_capture #(.N_CH(N_CH), .IDW(IDW)) u_cap (
    .sof_i(sof_i), .eof_i(eof_i), .brs_i(brs_i), .berr_i(berr_i), .undr_i(undr_i),
    .sof_req_i(sof_req_i), .eof_req_i(eof_req_i), .frame_id_i(frame_id_i),
    .ldd_i(ldd_i), .acb_i(acb_i), .oundr_i(oundr_i), .rdst_i(rdst_i), .cmdd_i(cmdd_i),
    .pmask_i(pmask_w), .smask_i(smask_w),
    .pset_o(pset_w), .sset_o(sset_w), .ber_hit_o(ber_hit_w), .ber_ch_o(ber_ch_w),
    .sum_hit_o(sum_hit_w), .sum_id_o(sum_id_w)
  );

  dc_irq_regs #(.IDW(IDW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .pset_i(pset_w), .sset_i(sset_w), .ber_hit_i(ber_hit_w), .ber_ch_i(ber_ch_w),
    .sum_hit_i(sum_hit_w), .sum_id_i(sum_id_w),
    .ctrl_en_o(ctrl_w), .pmask_o(pmask_w), .smask_o(smask_w),
    .pstat_o(pstat_w), .sstat_o(sstat_w), .rd_data_o(rd_data_o)
  );

  dc_irq_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pflag_i(pstat_w[PW-1:0]), .pmask_i(pmask_w),
    .sstat_i(sstat_w), .smask_i(smask_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/dc_irq_chk.sv
module dc_irq_chk
  import dc_irq_pkg::*;
#(
  parameter int N_CH = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] sof_i,
  input logic [N_CH-1:0] sof_req_i,
  input logic [N_CH-1:0] berr_i,
  input logic            wr_en_i,
  input logic [AW-1:0]   wr_addr_i,
  input logic [DW-1:0]   wr_data_i,
  input logic            irq_o,
  input logic            ctrl,
  input logic [DW-1:0]   pstat,
  input logic [SW-1:0]   sstat,
  input logic [PW-1:0]   pmask,
  input logic [SW-1:0]   smask
);
  logic wr_ps, wr_ss, wr_ct, lvl, unused_chk;
  assign wr_ps = wr_en_i && (wr_addr_i == A_PSTAT);
  assign wr_ss = wr_en_i && (wr_addr_i == A_SSTAT);
  assign wr_ct = wr_en_i && (wr_addr_i == A_CTRL);
  assign lvl   = (|(pstat[PW-1:0] & ~pmask)) | (|(sstat & ~smask));
  assign unused_chk = ^{pstat[DW-1:BCH_LO+BCH_W], pstat[BCH_LO-1:PW], wr_data_i[DW-1:1]};

  AST_SOF0_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pstat[P_SOF0] && sof_i[0] && !sof_req_i[0]) |=> !pstat[P_SOF0]); // R2

  AST_BER_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_i[0] |=> (pstat[P_BER] && pstat[BCH_LO +: BCH_W] == '0)); // R4

  AST_BER_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|berr_i) |=> pstat[P_SUM]); // R5

  AST_QD_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ct && ctrl && !wr_data_i[0]) |=> pstat[P_QD]); // R8

  AST_SEC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ss && sstat[16]) |=> sstat[16]); // R7

  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(lvl))); // R10

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i[0] && sof_req_i[0] && wr_ps && wr_data_i[P_SOF0]) |=> pstat[P_SOF0]); // R11
endmodule

bind dc_irq_status dc_irq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .sof_req_i(sof_req_i), .berr_i(berr_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .irq_o(irq_o),
  .ctrl(ctrl_w), .pstat(pstat_w), .sstat(sstat_w), .pmask(pmask_w), .smask(smask_w)
);

// File: tb/dc_irq_status_tb_top.sv
`timescale 1ns/1ps
module dc_irq_status_tb_top;
  localparam int N_CH = 7;
  localparam int IDW  = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_CH-1:0] sof_i = '0, eof_i = '0, brs_i = '0, berr_i = '0, undr_i = '0;
  logic [N_CH-1:0] sof_req_i = '0, eof_req_i = '0;
  logic [N_CH*IDW-1:0] frame_id_i;
  logic ldd_i = 0, acb_i = 0, oundr_i = 0, rdst_i = 0, cmdd_i = 0;
  logic wr_en_i = 0;
  logic [2:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic irq_o;

  always #4 clk_i = ~clk_i;

  dc_irq_status #(.N_CH(N_CH), .IDW(IDW)) dut_i (.*);

  typedef struct {
    bit          is_irq;
    logic [2:0]  addr;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int pend = 0;
  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] fid(int c);
    return 32'hA5C0_0000 | c;
  endfunction

  initial for (int c = 0; c < N_CH; c++) frame_id_i[c*IDW +: IDW] = fid(c);

  // monitor: pops expectations and compares against the ports
  initial begin
    item_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      if (!it.is_irq) rd_addr_i = it.addr;
      #0.2;
      checks++;
      if (it.is_irq) begin
        if (irq_o !== it.val[0]) begin
          errors++;
          $display("FAIL %s irq: got %0b exp %0b", it.tag, irq_o, it.val[0]);
        end
      end else if (rd_data_o !== it.val) begin
        errors++;
        $display("FAIL %s reg %0d: got %h exp %h", it.tag, it.addr, rd_data_o, it.val);
      end
      pend--;
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] v, input string t);
    item_t it;
    it.is_irq = 0; it.addr = a; it.val = v; it.tag = t;
    pend++;
    q.push_back(it);
  endtask

  task automatic expect_irq(input logic v, input string t);
    item_t it;
    it.is_irq = 1; it.addr = '0; it.val = {31'b0, v}; it.tag = t;
    pend++;
    q.push_back(it);
  endtask

  task automatic settle();
    wait (pend == 0);
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic clear_ev();
    sof_i = '0; eof_i = '0; brs_i = '0; berr_i = '0; undr_i = '0;
    ldd_i = 0; acb_i = 0; oundr_i = 0; rdst_i = 0; cmdd_i = 0; wr_en_i = 0;
  endtask

  // events are set by the caller; one edge captures them, one more settles irq
  task automatic fire();
    tick(); clear_ev(); tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    tick(); wr_en_i = 0; tick();
  endtask

  task automatic do_reset();
    clear_ev();
    rst_ni = 0; tick(); tick(); rst_ni = 1; tick();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    expect_reg(3'd0, 32'h0, "R1 ctrl");
    expect_reg(3'd1, 32'h0, "R1 pmask");
    expect_reg(3'd3, 32'h0, "R1 pstat");
    expect_reg(3'd4, 32'h0, "R1 sstat");
    expect_reg(3'd5, 32'h0, "R1 liid");
    expect_irq(1'b0, "R1 irq");
    settle();

    // R2 R5 channel 0 start of frame, unmasked
    sof_req_i = '1; eof_req_i = '1;
    sof_i[0] = 1; fire();
    expect_reg(3'd3, 32'h0000_0402, "R2 sof0");
    expect_reg(3'd5, fid(0), "R5 liid ch0");
    expect_irq(1'b1, "R10 irq set");
    settle();

    // R6 clear, irq drops a cycle later
    wr(3'd3, 32'h0000_0fff);
    expect_reg(3'd3, 32'h0, "R6 pstat clear");
    expect_reg(3'd5, fid(0), "R5 liid holds");
    expect_irq(1'b0, "R10 irq clear");
    settle();

    // R2 gating: sof without request ignored, eof/branch/underrun recorded
    sof_req_i[0] = 0;
    sof_i[0] = 1; eof_i[0] = 1; brs_i[0] = 1; undr_i[0] = 1; fire();
    expect_reg(3'd3, 32'h0000_0710, "R2 gated sof0");
    expect_irq(1'b1, "R10 irq");
    settle();

    do_reset();
    sof_req_i = '1; eof_req_i = '1;
    // R3 R5 masked ch3 end of frame
    wr(3'd2, 32'h0000_0400);
    eof_i[3] = 1; fire();
    expect_reg(3'd4, 32'h0000_0400, "R3 eof ch3");
    expect_reg(3'd3, 32'h0, "R5 masked no summary");
    expect_reg(3'd5, 32'h0, "R5 masked no id");
    expect_irq(1'b0, "R10 masked irq");
    settle();
    sof_i[3] = 1; fire();
    expect_reg(3'd4, 32'h0000_0404, "R3 sof ch3");
    expect_reg(3'd3, 32'h0000_0400, "R5 summary ch3");
    expect_reg(3'd5, fid(3), "R5 liid ch3");
    expect_irq(1'b1, "R10 irq ch3");
    settle();

    do_reset();
    sof_req_i = '1; eof_req_i = '1;
    // R3 R7 spread of secondary events, then clear all ones
    brs_i[1] = 1; undr_i[1] = 1; undr_i[4] = 1; sof_i[6] = 1; eof_i[6] = 1; brs_i[6] = 1;
    fire();
    expect_reg(3'd4, 32'h0921_2020, "R3 secondary map");
    expect_reg(3'd3, 32'h0000_0420, "R3 ch1 underrun primary");
    expect_reg(3'd5, fid(1), "R5 lowest channel id");
    settle();
    wr(3'd4, 32'hffff_ffff);
    expect_reg(3'd4, 32'h0901_0000, "R7 clear window");
    expect_irq(1'b1, "R10 irq leftovers");
    settle();

    do_reset();
    // R4 two bus errors, lowest wins; then R6 clear of field
    berr_i[4] = 1; berr_i[2] = 1; fire();
    expect_reg(3'd3, 32'h2000_0404, "R4 ber ch2");
    expect_reg(3'd5, fid(2), "R5 liid ber");
    settle();
    wr(3'd3, 32'h0000_0004);
    expect_reg(3'd3, 32'h0000_0400, "R6 ber field clear");
    settle();
    cmdd_i = 1; fire();
    wr(3'd3, 32'hffff_ffff);
    expect_reg(3'd3, 32'h0000_1000, "R6 bit12 kept");
    expect_irq(1'b1, "R9 cmd irq");
    settle();

    do_reset();
    // R9 controller events
    ldd_i = 1; acb_i = 1; oundr_i = 1; rdst_i = 1; fire();
    expect_reg(3'd3, 32'h0000_0849, "R9 ctrl events");
    settle();
    // R8 quick disable only on 1->0
    wr(3'd0, 32'h0);
    expect_reg(3'd3, 32'h0000_0849, "R8 no qd from 0");
    settle();
    wr(3'd0, 32'h1);
    expect_reg(3'd3, 32'h0000_0849, "R8 no qd on set");
    expect_reg(3'd0, 32'h1, "R8 enable");
    settle();
    wr(3'd0, 32'h0);
    expect_reg(3'd3, 32'h0000_08c9, "R8 qd");
    settle();
    // R10 mask write reaches irq one edge later
    wr_en_i = 1; wr_addr_i = 3'd1; wr_data_i = 32'h0000_1fff;
    tick(); wr_en_i = 0;
    expect_irq(1'b1, "R10 lag");
    settle();
    tick();
    expect_irq(1'b0, "R10 masked");
    settle();

    do_reset();
    sof_req_i = '1;
    // R11 event beats clear in same cycle
    sof_i[0] = 1; berr_i[3] = 1;
    wr_en_i = 1; wr_addr_i = 3'd3; wr_data_i = 32'h0000_0006;
    fire();
    expect_reg(3'd3, 32'h3000_0406, "R11 event wins");
    expect_reg(3'd5, fid(0), "R11 liid");
    settle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule